// File: doc/BRIEF.md
# Single-Wire Bus CRC-8 Checker

This block computes the 8-bit cyclic redundancy code that protects device identifiers and data on a single-wire sensor bus. A byte stream comes in on a valid/ready interface, one byte per cycle. Each beat carries two markers: one for the first byte of a message and one for the last. The block keeps a running remainder across the message. When it accepts the last byte, it presents the final remainder for one cycle.

The code uses the reflected form of x^8+x^5+x^4+1 (constant 0x8C). Bits are taken least significant first and the seed is zero. For a single byte, the result equals a 256-entry lookup indexed by (remainder XOR byte). The block forms that result with eight chained one-bit shift steps, so no table is stored. If a message ends with its own CRC byte, the final remainder is zero. A match flag reports this condition, so a receiver can check a whole identifier or scratchpad read in one pass.

Top module: `sbcrc_unit`

## Requirements
- R1: While reset is held and after reset is released, out_valid, out_ok and out_crc are all 0 until the first last-marked byte is accepted.
- R2: in_ready is 1 on every cycle, so a byte is accepted on every cycle in which in_valid is 1.
- R3: Each accepted byte updates the remainder. The byte's bits are fed least significant bit first. For each bit, if (rem[0] XOR bit) is 1 then rem becomes (rem >> 1) XOR 0x8C, otherwise rem becomes rem >> 1. With seed 0, the single-byte results are 0x00→0x00, 0x01→0x5E, 0x02→0xBC, 0x80→0x8C and 0xFF→0x35.
- R4: A byte with in_first set starts from the seed 0 in the same cycle it is accepted, whatever remainder was left from earlier bytes.
- R5: Bytes of a message are folded in the order they are accepted, and each remainder feeds the next byte.
- R6: out_valid is 1 for exactly one cycle, the cycle after a byte with in_last set is accepted. In that cycle out_crc carries the remainder that includes that byte.
- R7: out_ok is 1 with a result exactly when the final remainder is 0. A message followed by its own CRC byte gives out_crc 0x00 and out_ok 1.
- R8: Cycles with in_valid at 0 leave the remainder unchanged, so idle gaps inside a message do not change its result.
- R9: out_crc and out_ok hold their values from one result until the next result.
- R10: After a last-marked byte the remainder returns to the seed, so a following message gives the correct result even when in_first is not set on its first byte.
- R11: A byte with both in_first and in_last set is a one-byte message. Its result is the table value of that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts a byte (always 1) |
| in_data | input | 8 | Input byte |
| in_first | input | 1 | Byte is the first of a message |
| in_last | input | 1 | Byte is the last of a message |
| out_valid | output | 1 | Result pulse |
| out_crc | output | 8 | Final remainder of the latest message |
| out_ok | output | 1 | Final remainder was zero |

## Verification
The properties take it for granted that the markers and the data mean something only when in_valid is high. They also assume that a first marker may arrive at any point, even inside a message that is still open. The bench therefore drives the markers and data only together with in_valid, at the falling edge, and clears in_valid between messages and in its gap tests. It also restarts a message in the middle on purpose, to exercise the seed reload. A last marker can be followed at once by a byte with no first marker. The assertions on the remainder's return to seed rely on this, and one scenario drives exactly that stream.

// File: rtl/sbcrc_pkg.sv
package sbcrc_pkg;
  localparam int unsigned CRC_W  = 8;
  localparam int unsigned BEAT_W = 8;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BEAT_W-1:0] beat_t;

  typedef struct packed {
    logic ok;
    crc_t crc;
  } result_t;

  localparam crc_t POLY_REFL = 8'h8C;
  localparam crc_t SEED_ZERO = 8'h00;

  // one LSB-first shift step of the reflected division
  function automatic crc_t crc_shift1(crc_t c, logic b, crc_t poly);
    logic fb;
    fb = c[0] ^ b;
    return fb ? ((c >> 1) ^ poly) : (c >> 1);
  endfunction

  // one whole byte, bit 0 first
  function automatic crc_t crc_of_beat(crc_t c, beat_t d, crc_t poly);
    crc_t r;
    r = c;
    for (int i = 0; i < BEAT_W; i++) r = crc_shift1(r, d[i], poly);
    return r;
  endfunction
endpackage

// File: rtl/sbcrc_bit_stage.sv
module sbcrc_bit_stage
  import sbcrc_pkg::*;
#(
  parameter crc_t POLY = POLY_REFL
) (
  input  crc_t rem_i,
  input  logic bit_i,
  output crc_t rem_o
);
  logic fb;
  crc_t shifted;

  assign fb      = rem_i[0] ^ bit_i;
  assign shifted = {1'b0, rem_i[CRC_W-1:1]};
  assign rem_o   = fb ? (shifted ^ POLY) : shifted;
endmodule

// File: rtl/sbcrc_beat_xform.sv
module sbcrc_beat_xform
  import sbcrc_pkg::*;
#(
  parameter crc_t POLY = POLY_REFL
) (
  input  crc_t  base_i,
  input  beat_t data_i,
  output crc_t  next_o
);
  crc_t chain [BEAT_W+1];

  assign chain[0] = base_i;

  for (genvar g = 0; g < BEAT_W; g++) begin : g_step
    sbcrc_bit_stage #(.POLY(POLY)) u_stage (
      .rem_i (chain[g]),
      .bit_i (data_i[g]),
      .rem_o (chain[g+1])
    );
  end

  assign next_o = chain[BEAT_W];
endmodule

// File: rtl/sbcrc_remainder.sv
module sbcrc_remainder
  import sbcrc_pkg::*;
#(
  parameter crc_t SEED = SEED_ZERO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic first_i,
  input  logic last_i,
  input  crc_t next_i,
  output crc_t base_o,
  output crc_t rem_o
);
  crc_t rem_q;

  // a first marker bypasses the stored value in the same cycle
  assign base_o = first_i ? SEED : rem_q;
  assign rem_o  = rem_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= SEED;
    end else if (take_i) begin
      rem_q <= last_i ? SEED : next_i;
    end
  end
endmodule

// File: rtl/sbcrc_result.sv
module sbcrc_result
  import sbcrc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  input  logic last_i,
  input  crc_t next_i,
  output logic valid_o,
  output crc_t crc_o,
  output logic ok_o
);
  logic    fire;
  result_t res_q;

  assign fire = take_i & last_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_o <= fire;
      if (fire) begin
        res_q.crc <= next_i;
        res_q.ok  <= (next_i == '0);
      end
    end
  end

  assign crc_o = res_q.crc;
  assign ok_o  = res_q.ok;
endmodule

// File: rtl/sbcrc_unit.sv
module sbcrc_unit
  import sbcrc_pkg::*;
#(
  parameter crc_t POLY = POLY_REFL,
  parameter crc_t SEED = SEED_ZERO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  output logic              out_valid,
  output logic [CRC_W-1:0]  out_crc,
  output logic              out_ok
);
  logic take;
  crc_t base_rem;
  crc_t next_rem;
  crc_t rem_now;

  assign in_ready = 1'b1;
  assign take     = in_valid & in_ready;

  sbcrc_remainder #(.SEED(SEED)) u_rem (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .first_i (in_first),
    .last_i  (in_last),
    .next_i  (next_rem),
    .base_o  (base_rem),
    .rem_o   (rem_now)
  );

  sbcrc_beat_xform #(.POLY(POLY)) u_xform (
    .base_i (base_rem),
    .data_i (in_data),
    .next_o (next_rem)
  );

  sbcrc_result u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .take_i  (take),
    .last_i  (in_last),
    .next_i  (next_rem),
    .valid_o (out_valid),
    .crc_o   (out_crc),
    .ok_o    (out_ok)
  );
endmodule

// File: rtl/sbcrc_unit_checker.sv
module sbcrc_unit_checker
  import sbcrc_pkg::*;
#(
  parameter crc_t POLY = POLY_REFL,
  parameter crc_t SEED = SEED_ZERO
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_first,
  input logic       in_last,
  input logic       out_valid,
  input logic [7:0] out_crc,
  input logic       out_ok,
  input crc_t       rem_now
);
  assert_result_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_last));

  assert_ok_means_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_ok == (out_crc == '0)));

  assert_result_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_last) |-> ($stable(out_crc) && $stable(out_ok)));

  assert_idle_keeps_rem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(rem_now));

  assert_seed_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> (rem_now == SEED));

  assert_first_reseeds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && !in_last) |=>
      (rem_now == crc_of_beat(SEED, $past(in_data), POLY)));

  assert_single_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && in_last) |=>
      (out_valid && out_crc == crc_of_beat(SEED, $past(in_data), POLY)));
endmodule

bind sbcrc_unit sbcrc_unit_checker #(.POLY(POLY), .SEED(SEED)) u_chk (.*);

// File: tb/sbcrc_unit_bench.sv
module sbcrc_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_first = 1'b0;
  logic       in_last = 1'b0;
  logic       out_valid;
  logic [7:0] out_crc;
  logic       out_ok;

  int total = 0;
  int bad   = 0;
  logic [7:0] msg [0:15];
  int msg_len = 0;

  always #2 clk = ~clk;

  sbcrc_unit u_sbcrc_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .out_valid(out_valid), .out_crc(out_crc), .out_ok(out_ok)
  );

  // reference: fold the whole byte in first, then eight reflected divisions
  function automatic logic [7:0] model_byte(logic [7:0] c, logic [7:0] d);
    logic [7:0] v;
    v = c ^ d;
    for (int k = 0; k < 8; k++) begin
      if (v[0]) v = (v >> 1) ^ 8'h8C;
      else      v = v >> 1;
    end
    return v;
  endfunction

  function automatic logic [7:0] model_msg();
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < msg_len; i++) c = model_byte(c, msg[i]);
    return c;
  endfunction

  task automatic check(input bit cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic f, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_first = f; in_last = l;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    end
  endtask

  // negedge after the accepting edge: result visible, then the pulse must drop
  task automatic expect_result(input logic [7:0] exp, input string tag);
    idle(1);
    check(out_valid === 1'b1, {tag, " valid"}, out_valid, 1);
    check(out_crc === exp, {tag, " crc"}, out_crc, exp);
    check(out_ok === (exp == 8'h00), {tag, " ok"}, out_ok, exp == 8'h00);
    idle(1);
    check(out_valid === 1'b0, "R6 pulse one cycle", out_valid, 0);
  endtask

  task automatic send_msg(input int gap, input bit mark_first);
    for (int i = 0; i < msg_len; i++) begin
      put(msg[i], mark_first && (i == 0), i == msg_len - 1);
      if (gap > 0 && i < msg_len - 1) idle(gap);
    end
  endtask

  task automatic load_id();
    msg[0] = 8'h28; msg[1] = 8'hA1; msg[2] = 8'h3F; msg[3] = 8'h07;
    msg[4] = 8'h00; msg[5] = 8'hC4; msg[6] = 8'h91;
    msg_len = 7;
  endtask

  task automatic t_reset();
    check(out_valid === 1'b0, "R1 valid in reset", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    check(out_valid === 1'b0, "R1 valid", out_valid, 0);
    check(out_crc === 8'h00, "R1 crc", out_crc, 0);
    check(out_ok === 1'b0, "R1 ok", out_ok, 0);
    check(in_ready === 1'b1, "R2 ready", in_ready, 1);
  endtask

  task automatic t_known_points();
    put(8'h00, 1, 1); expect_result(8'h00, "R3 0x00");
    put(8'h01, 1, 1); expect_result(8'h5E, "R3 0x01");
    put(8'h02, 1, 1); expect_result(8'hBC, "R3 0x02");
    put(8'h80, 1, 1); expect_result(8'h8C, "R3 0x80");
    put(8'hFF, 1, 1); expect_result(8'h35, "R11 0xFF");
  endtask

  task automatic t_all_single();
    for (int b = 0; b < 256; b++) begin
      put(b[7:0], 1, 1);
      expect_result(model_byte(8'h00, b[7:0]), "R3 R11 single byte");
    end
  endtask

  task automatic t_multi();
    logic [7:0] c;
    load_id();
    c = model_msg();
    send_msg(0, 1);
    expect_result(c, "R5 stream");
    msg[7] = c; msg_len = 8;
    send_msg(0, 1);
    expect_result(8'h00, "R7 with own crc");
    msg[7] = c ^ 8'h01;
    send_msg(0, 1);
    expect_result(model_msg(), "R7 corrupted");
    check(out_ok === 1'b0, "R7 corrupted not ok", out_ok, 0);
  endtask

  task automatic t_gaps();
    load_id();
    send_msg(3, 1);
    expect_result(model_msg(), "R8 gaps");
  endtask

  task automatic t_restart();
    put(8'h55, 1, 0); put(8'hAA, 0, 0); put(8'h13, 0, 0);
    load_id();
    send_msg(0, 1);
    expect_result(model_msg(), "R4 restart");
  endtask

  task automatic t_hold();
    logic [7:0] keep;
    load_id();
    send_msg(0, 1);
    expect_result(model_msg(), "R9 setup");
    keep = out_crc;
    idle(5);
    check(out_valid === 1'b0, "R9 no pulse", out_valid, 0);
    check(out_crc === keep, "R9 crc held", out_crc, keep);
    put(8'h77, 1, 0); idle(1);
    check(out_crc === keep, "R9 held over non-last", out_crc, keep);
    put(8'h01, 0, 1); idle(1);
  endtask

  task automatic t_no_first();
    put(8'h3C, 1, 1);
    msg[0] = 8'h9E; msg[1] = 8'h42; msg[2] = 8'hD0; msg_len = 3;
    send_msg(0, 0);
    expect_result(model_msg(), "R10 no first marker");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_known_points();
    t_all_single();
    t_multi();
    t_gaps();
    t_restart();
    t_hold();
    t_no_first();
    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule